// File: doc/BRIEF.md
# Banked Context Identifier Register

This block holds the 32-bit context identifier that debug comparators and trace logic use to recognise the running process. It sits behind a coprocessor-style system register port. Each cycle the port may present one request: a read or write flag, the five encoding fields, the current exception level, a write word and a group of hypervisor and security control bits. The block decodes whether the request addresses this register. It then completes the access, reports it as undefined, or raises a hypervisor trap carrying a syndrome code.

Storage is split into three copies: a common copy, a non-secure copy and a secure copy. A completed access reads or writes exactly one of them. The choice depends on the exception level, on whether the highest level runs in 32-bit state, and on the non-secure state bit. The same selection rule drives a continuous context ID output. That output is also split into a process ID view and an address space ID view, under the extended-address control. Contents after reset are unspecified.

Top module: `ctx_id_bank`

## Requirements
- R1: A request hits only when req_cp=4'b1111, req_op1=3'b000, req_crn=4'b1101, req_crm=4'b0000 and req_op2=3'b001 with req_valid high. A miss raises none of done, undef or trap_valid, returns rdata of zero and changes no copy.
- R2: A hit with cur_el=0 raises undef, for both reads and writes, and leaves every copy unchanged.
- R3: A hit at cur_el=1 with el2_on=1 and trap_c13=1 traps for both reads and writes, whatever the other trap bits hold. Every trap drives trap_el=2 and trap_code=8'h03 in the request cycle; both are zero when no trap is raised.
- R4: At cur_el=1 with el2_on=1, a read traps when trap_vm_rd=1 and a write traps when trap_vm_wr=1. Each bit has no effect on the other access direction.
- R5: No trap is raised when el2_on=0 or when cur_el is 2 or 3, whatever the trap bits hold. In those cases a hit completes (done=1).
- R6: A completed access at cur_el 1 or 2 uses the non-secure copy when el3_is32=1 and the common copy when el3_is32=0.
- R7: A completed access at cur_el=3 uses the secure copy when sec_ns=0 and the non-secure copy when sec_ns=1.
- R8: Read data appears on rdata in the same cycle as a completed read and is zero otherwise. A completed write updates its copy at the next rising clock edge, so the next read sees it.
- R9: ctx_id always shows the copy that an access would select under the present cur_el, el3_is32 and sec_ns, with level 0 following the level 1 and 2 rule.
- R10: With eae=0, proc_id is ctx_id[31:8] zero-extended and asid is ctx_id[7:0]. With eae=1, proc_id is all 32 bits of ctx_id and asid is zero.
- R11: An undefined or trapped write leaves all three copies unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, used to qualify checks only; storage has no reset value |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cp | input | 4 | Coprocessor number field |
| req_op1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_op2 | input | 3 | Second opcode field |
| cur_el | input | 2 | Current exception level |
| wdata | input | 32 | Write data |
| el2_on | input | 1 | Hypervisor level enabled |
| trap_c13 | input | 1 | Trap all accesses to register group 13 |
| trap_vm_rd | input | 1 | Trap reads of memory-control registers |
| trap_vm_wr | input | 1 | Trap writes of memory-control registers |
| el3_is32 | input | 1 | Highest level present and running in 32-bit state |
| sec_ns | input | 1 | Non-secure state bit |
| eae | input | 1 | Extended address format selected |
| hit | output | 1 | Request decodes to this register |
| done | output | 1 | Access completed |
| undef | output | 1 | Access undefined |
| trap_valid | output | 1 | Hypervisor trap raised |
| trap_el | output | 2 | Trap target level |
| trap_code | output | 8 | Trap syndrome code |
| rdata | output | 32 | Read data |
| ctx_id | output | 32 | Active context ID for debug and trace |
| proc_id | output | 32 | Process ID view of ctx_id |
| asid | output | 8 | Address space ID view of ctx_id |

## Verification
The embedded properties assume that each request is presented for a single cycle. They also assume that request and control inputs are steady around the rising edge, so each access has exactly one outcome and the state-hold check after a fault refers to that access alone. The stimulus changes every input on the falling edge only and draws cur_el over all four values, with random control bits. Copies that have not yet been written hold unspecified values, so the reference model compares read data and the context views only for copies it has seen written.

// File: rtl/ctx_id_bank.sv
module ctx_id_bank #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter logic [7:0] TRAP_EC = 8'h03
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [3:0]    req_cp,
  input  logic [2:0]    req_op1,
  input  logic [3:0]    req_crn,
  input  logic [3:0]    req_crm,
  input  logic [2:0]    req_op2,
  input  logic [1:0]    cur_el,
  input  logic [DW-1:0] wdata,
  input  logic          el2_on,
  input  logic          trap_c13,
  input  logic          trap_vm_rd,
  input  logic          trap_vm_wr,
  input  logic          el3_is32,
  input  logic          sec_ns,
  input  logic          eae,
  output logic          hit,
  output logic          done,
  output logic          undef,
  output logic          trap_valid,
  output logic [1:0]    trap_el,
  output logic [7:0]    trap_code,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ctx_id,
  output logic [DW-1:0] proc_id,
  output logic [AW-1:0] asid
);
  typedef enum logic [1:0] {BK_CMN, BK_NS, BK_SEC} bank_e;

  logic [DW-1:0] cmn_q, ns_q, sec_q, cur_val;
  bank_e         sel;
  logic          el1_trap;

  assign hit = req_valid && req_cp == 4'b1111 && req_op1 == 3'b000 &&
               req_crn == 4'b1101 && req_crm == 4'b0000 && req_op2 == 3'b001;

  assign sel = (cur_el == 2'd3) ? (sec_ns ? BK_NS : BK_SEC)
                                : (el3_is32 ? BK_NS : BK_CMN);

  assign el1_trap   = cur_el == 2'd1 && el2_on &&
                      (trap_c13 || (req_write ? trap_vm_wr : trap_vm_rd));
  assign undef      = hit && cur_el == 2'd0;
  assign trap_valid = hit && el1_trap;
  assign done       = hit && !undef && !trap_valid;
  assign trap_el    = trap_valid ? 2'd2 : 2'd0;
  assign trap_code  = trap_valid ? TRAP_EC : 8'h00;

  always_comb begin
    case (sel)
      BK_NS:   cur_val = ns_q;
      BK_SEC:  cur_val = sec_q;
      default: cur_val = cmn_q;
    endcase
  end

  assign rdata   = (done && !req_write) ? cur_val : '0;
  assign ctx_id  = cur_val;
  assign proc_id = eae ? ctx_id : {{AW{1'b0}}, ctx_id[DW-1:AW]};
  assign asid    = eae ? '0 : ctx_id[AW-1:0];

  always_ff @(posedge clk) begin
    if (done && req_write) begin
      case (sel)
        BK_NS:   ns_q  <= wdata;
        BK_SEC:  sec_q <= wdata;
        default: cmn_q <= wdata;
      endcase
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, undef, trap_valid})); // R1
  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rdata == '0 && !undef && !trap_valid && !done)); // R1
  AST_EL0_NEVER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_el == 2'd0) |-> (!done && !trap_valid)); // R2
  AST_TRAP_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_code == TRAP_EC && trap_el == 2'd2)); // R3
  AST_NO_TRAP_OUTSIDE_EL1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_el != 2'd1 || !el2_on) |-> !trap_valid); // R5
  AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (undef || trap_valid) |=> ($stable(cmn_q) && $stable(ns_q) && $stable(sec_q))); // R11
  AST_SECURE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req_write && cur_el == 2'd3 && !sec_ns) |=> sec_q == $past(wdata)); // R7
endmodule

// File: tb/ctx_id_bank_tb_top.sv
`timescale 1ns/1ps
module ctx_id_bank_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_write;
  logic [3:0] req_cp, req_crn, req_crm;
  logic [2:0] req_op1, req_op2;
  logic [1:0] cur_el;
  logic [31:0] wdata;
  logic el2_on, trap_c13, trap_vm_rd, trap_vm_wr, el3_is32, sec_ns, eae;
  logic hit, done, undef, trap_valid;
  logic [1:0] trap_el;
  logic [7:0] trap_code, asid;
  logic [31:0] rdata, ctx_id, proc_id;

  ctx_id_bank dut_i (.*);

  logic [31:0] m_val [3];
  bit          m_known [3];
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs already driven after a falling edge; checks, then advances one cycle
  task automatic step();
    int b;
    bit e_hit, e_undef, e_trap, e_done;
    #1;
    e_hit = req_valid && req_cp == 4'hF && req_op1 == 3'd0 && req_crn == 4'hD &&
            req_crm == 4'h0 && req_op2 == 3'd1;
    if (cur_el == 2'd3) b = sec_ns ? 1 : 2;
    else                b = el3_is32 ? 1 : 0;
    e_undef = e_hit && (cur_el == 2'd0);
    e_trap  = e_hit && (cur_el == 2'd1) && el2_on &&
              (trap_c13 || (req_write ? trap_vm_wr : trap_vm_rd));
    e_done  = e_hit && !e_undef && !e_trap;
    chk("R1 hit", {31'b0, hit}, {31'b0, e_hit});
    chk("R2 undef", {31'b0, undef}, {31'b0, e_undef});
    chk("R4 trap_valid", {31'b0, trap_valid}, {31'b0, e_trap});
    chk("R3 trap_el", {30'b0, trap_el}, e_trap ? 32'd2 : 32'd0);
    chk("R3 trap_code", {24'b0, trap_code}, e_trap ? 32'h03 : 32'h0);
    chk("R5 done", {31'b0, done}, {31'b0, e_done});
    if (e_done && !req_write) begin
      if (m_known[b]) chk("R8 R6 R7 R11 rdata", rdata, m_val[b]);
    end else chk("R8 rdata idle", rdata, 32'h0);
    if (m_known[b]) begin
      chk("R9 ctx_id", ctx_id, m_val[b]);
      chk("R10 proc_id", proc_id, eae ? m_val[b] : (m_val[b] >> 8));
      chk("R10 asid", {24'b0, asid}, eae ? 32'h0 : {24'b0, m_val[b][7:0]});
    end
    @(posedge clk);
    if (rst_n && e_done && req_write) begin
      m_val[b]   = wdata;
      m_known[b] = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic ctl(input bit e2, input bit c13, input bit vr, input bit vw,
                     input bit e3, input bit ns, input bit ea);
    el2_on = e2; trap_c13 = c13; trap_vm_rd = vr; trap_vm_wr = vw;
    el3_is32 = e3; sec_ns = ns; eae = ea;
  endtask

  task automatic acc(input bit w, input logic [1:0] el, input logic [31:0] d);
    req_valid = 1'b1; req_write = w; cur_el = el; wdata = d;
    req_cp = 4'hF; req_op1 = 3'd0; req_crn = 4'hD; req_crm = 4'h0; req_op2 = 3'd1;
    step();
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    ctl(0, 0, 0, 0, 0, 0, 0);
    req_valid = 0; req_write = 0; cur_el = 0; wdata = 0;
    req_cp = 0; req_op1 = 0; req_crn = 0; req_crm = 0; req_op2 = 0;
    @(negedge clk);
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R7: EL3 banking; R6: common vs non-secure at EL2/EL1
    ctl(0, 0, 0, 0, 1, 0, 0); acc(1, 2'd3, 32'hA1A2_A3A4);
    ctl(0, 0, 0, 0, 1, 1, 0); acc(1, 2'd3, 32'hB1B2_B3B4);
    ctl(0, 0, 0, 0, 0, 1, 0); acc(1, 2'd2, 32'hC1C2_C3C4);
    ctl(0, 0, 0, 0, 1, 1, 0); acc(0, 2'd1, 32'h0);
    ctl(0, 0, 0, 0, 0, 1, 0); acc(0, 2'd1, 32'h0);
    ctl(0, 0, 0, 0, 1, 0, 0); acc(0, 2'd3, 32'h0);
    ctl(0, 0, 0, 0, 1, 0, 1); acc(0, 2'd3, 32'h0);   // R10 eae=1
    // R2 / R11: EL0 write then read back
    ctl(0, 0, 0, 0, 1, 1, 0); acc(1, 2'd0, 32'hDEAD_0000); acc(0, 2'd1, 32'h0);
    // R3: trap_c13 beats everything
    ctl(1, 1, 0, 0, 1, 1, 0); acc(1, 2'd1, 32'h1111_1111); acc(0, 2'd1, 32'h0);
    ctl(0, 0, 0, 0, 1, 1, 0); acc(0, 2'd1, 32'h0);
    // R4: direction-specific traps
    ctl(1, 0, 0, 1, 1, 1, 0); acc(0, 2'd1, 32'h0); acc(1, 2'd1, 32'h2222_2222);
    ctl(1, 0, 1, 0, 1, 1, 0); acc(1, 2'd1, 32'h3333_3333); acc(0, 2'd1, 32'h0);
    // R5: no trap without EL2 or above EL1
    ctl(0, 1, 1, 1, 1, 1, 0); acc(1, 2'd1, 32'h4444_4444);
    ctl(1, 1, 1, 1, 1, 1, 0); acc(0, 2'd2, 32'h0); acc(1, 2'd3, 32'h5555_5555);
    // R1: encoding miss
    ctl(0, 0, 0, 0, 1, 1, 0);
    req_valid = 1; req_write = 1; cur_el = 2'd2; wdata = 32'h6666_6666;
    req_cp = 4'hF; req_op1 = 3'd0; req_crn = 4'hD; req_crm = 4'h0; req_op2 = 3'd0;
    step(); req_valid = 0;
    acc(0, 2'd2, 32'h0);

    for (int i = 0; i < 4000; i++) begin
      req_valid = ($urandom % 4) != 0;
      req_write = $urandom % 2;
      cur_el    = 2'($urandom % 4);
      wdata     = $urandom;
      req_cp = 4'hF; req_op1 = 3'd0; req_crn = 4'hD; req_crm = 4'h0; req_op2 = 3'd1;
      if ($urandom % 8 == 0) begin
        case ($urandom % 5)
          0: req_cp  = 4'($urandom);
          1: req_op1 = 3'($urandom);
          2: req_crn = 4'($urandom);
          3: req_crm = 4'($urandom);
          default: req_op2 = 3'($urandom);
        endcase
      end
      ctl($urandom % 2, ($urandom % 4) == 0, $urandom % 2, $urandom % 2,
          $urandom % 2, $urandom % 2, $urandom % 2);
      step();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule